// File: doc/BRIEF.md
# Envelope Level Sequencer with Indirect Rate Selection

This block shapes the loudness of one synthesizer voice. Once per frame tick it moves a 4-bit level (0 silent, 15 loudest, meant to drive an attenuator) according to a stage register. The stage register selects which packed rate byte supplies the step: the rise byte, the fall byte, the fade byte, or no byte at all (idle). There is no gate input. Raising the hold (sustain) level above the present level starts a new rise. Lowering it below the present level starts a fade.

Each rate byte carries a 3-bit signed side value in its low bits. While a stage with a non-zero side value is active, a wave-table offset moves by that amount on every tick, which lets the envelope sweep timbre the way a filter would. The offset is kept within 0..13 so it never reaches the noise entries of the table. For several voices, one instance is placed per voice. All register inputs are sampled only on a tick, so a write takes effect at the next tick.

Top module: `env_adsr_ctrl`

## Requirements
- R1: While reset is high and on the first cycle after it, `level_o` is 0 and `wave_o` is 0, and the stage is idle.
- R2: In a cycle without `tick_i`, neither output changes, even if any register input changes.
- R3: In the rise stage a tick adds the unsigned rate in bits [6:3] of `atk_i` to the level, when the sum stays below 15.
- R4: In the rise stage, when the sum reaches or passes 15, the level becomes 15 and the stage becomes fall.
- R5: In the fall stage a tick subtracts 16 minus bits [6:3] of `dec_i` (bit 7 set, so fields 1..15 give steps 15..1). If the result is at or below the hold level in `sus_i[3:0]`, or would go below zero, the level becomes the hold level and the stage becomes idle.
- R6: The fade stage follows the R5 rule, with the step taken from bits [6:3] of `rel_i`.
- R7: In the idle stage a tick keeps the level. A hold level above the level selects rise, a hold level below it selects fade, and an equal hold level stays idle.
- R8: On a tick in rise, fall or fade, bits [2:0] of that stage's byte, read as a signed value from -4 to 3, are added to `wave_o`. On a tick in the idle stage `wave_o` does not change.
- R9: `wave_o` is clamped to the range 0 to 13.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Frame tick, one update per high cycle |
| atk_i | input | 8 | Rise byte: 0, rate[3:0], side[2:0] |
| dec_i | input | 8 | Fall byte: 1, field[3:0], side[2:0] |
| sus_i | input | 8 | Hold byte: 1111, level[3:0] |
| rel_i | input | 8 | Fade byte: 1, field[3:0], side[2:0] |
| level_o | output | 4 | Current envelope level |
| wave_o | output | 4 | Wave-table offset, 0..13 |

## Verification
The level sequence is driven through a full rise, fall and hold cycle with a rate that overshoots 15. This separates clamping from plain addition and shows the change from rise to fall. A second rise uses a rate that lands on exactly 15, which checks the boundary of R4. Fades are arranged so that one lands below a non-zero hold level and another would go below zero, which separates settling on the hold level from wrapping around. Side values of both signs, chosen to push the offset past 13 and below 0, show the clamp. Writes made without a tick, and ticks in the idle stage, show that nothing moves.

// File: rtl/env_pkg.sv
package env_pkg;
  localparam int LVL_W    = 4;
  localparam int BYTE_W   = 8;
  localparam int RATE_LSB = 3;
  localparam int SIDE_W   = 3;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_RISE = 2'd1,
    PH_FALL = 2'd2,
    PH_FADE = 2'd3
  } env_phase_e;
endpackage

// File: rtl/env_step_calc.sv
module env_step_calc
  import env_pkg::*;
(
  input  env_phase_e               phase_q,
  input  logic [LVL_W-1:0]         level_q,
  input  logic [BYTE_W-1:0]        atk_b,
  input  logic [BYTE_W-1:0]        dec_b,
  input  logic [BYTE_W-1:0]        rel_b,
  input  logic [LVL_W-1:0]         hold_lvl,
  output env_phase_e               phase_d,
  output logic [LVL_W-1:0]         level_d,
  output logic                     side_en,
  output logic signed [SIDE_W-1:0] side_step
);
  localparam logic [LVL_W:0] LVL_TOP = {1'b0, {LVL_W{1'b1}}};

  logic [BYTE_W-1:0]    act_b;
  logic [LVL_W:0]       rise_sum;
  logic [LVL_W:0]       fall_mag;
  logic signed [LVL_W+1:0] fall_res;
  logic                 fall_done;

  always_comb begin
    unique case (phase_q)
      PH_RISE: act_b = atk_b;
      PH_FALL: act_b = dec_b;
      PH_FADE: act_b = rel_b;
      default: act_b = '0;
    endcase
  end

  assign rise_sum  = {1'b0, level_q} + {1'b0, act_b[RATE_LSB +: LVL_W]};
  assign fall_mag  = (LVL_W+1)'(1 << LVL_W) - {1'b0, act_b[RATE_LSB +: LVL_W]};
  assign fall_res  = $signed({2'b00, level_q}) - $signed({1'b0, fall_mag});
  assign fall_done = (fall_res <= $signed({2'b00, hold_lvl}));

  assign side_en   = (phase_q != PH_IDLE) && (act_b[SIDE_W-1:0] != '0);
  assign side_step = $signed(act_b[SIDE_W-1:0]);

  always_comb begin
    phase_d = phase_q;
    level_d = level_q;
    unique case (phase_q)
      PH_IDLE: begin
        if (hold_lvl > level_q)      phase_d = PH_RISE;
        else if (hold_lvl < level_q) phase_d = PH_FADE;
      end
      PH_RISE: begin
        if (rise_sum >= LVL_TOP) begin
          level_d = LVL_TOP[LVL_W-1:0];
          phase_d = PH_FALL;
        end else begin
          level_d = rise_sum[LVL_W-1:0];
        end
      end
      default: begin
        if (fall_done) begin
          level_d = hold_lvl;
          phase_d = PH_IDLE;
        end else begin
          level_d = fall_res[LVL_W-1:0];
        end
      end
    endcase
  end
endmodule

// File: rtl/env_wave_track.sv
module env_wave_track
  import env_pkg::*;
#(
  parameter int WAVE_W   = 4,
  parameter int WAVE_TOP = 13
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     upd,
  input  logic signed [SIDE_W-1:0] step,
  output logic [WAVE_W-1:0]        wave_q
);
  localparam int SUM_W = WAVE_W + 2;

  logic signed [SUM_W-1:0] sum_w;
  logic [WAVE_W-1:0]       wave_d;

  assign sum_w = $signed({2'b00, wave_q}) + SUM_W'(step);

  always_comb begin
    if (sum_w < 0)                           wave_d = '0;
    else if (sum_w > SUM_W'(WAVE_TOP))       wave_d = WAVE_W'(WAVE_TOP);
    else                                     wave_d = sum_w[WAVE_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)      wave_q <= '0;
    else if (upd) wave_q <= wave_d;
  end

  // R8: offset holds when no update is requested
  p_wave_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !upd |=> $stable(wave_q));
  // R8: a positive side value never lowers the offset
  p_wave_dir_r8: assert property (@(posedge clk) disable iff (rst)
    (upd && step > 0) |=> wave_q >= $past(wave_q));
  // R9: offset stays inside the table range
  p_wave_cap_r9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> wave_q <= WAVE_W'(WAVE_TOP));
endmodule

// File: rtl/env_adsr_ctrl.sv
module env_adsr_ctrl
  import env_pkg::*;
#(
  parameter int WAVE_W   = 4,
  parameter int WAVE_TOP = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  logic [7:0]        atk_i,
  input  logic [7:0]        dec_i,
  input  logic [7:0]        sus_i,
  input  logic [7:0]        rel_i,
  output logic [3:0]        level_o,
  output logic [WAVE_W-1:0] wave_o
);
  env_phase_e              phase_q, phase_d;
  logic [LVL_W-1:0]        level_q, level_d;
  logic                    side_en;
  logic signed [SIDE_W-1:0] side_step;
  logic                    unused_bits;

  assign unused_bits = ^{atk_i[7], dec_i[7], rel_i[7], sus_i[7:4]};

  env_step_calc u_calc (
    .phase_q  (phase_q),
    .level_q  (level_q),
    .atk_b    (atk_i),
    .dec_b    (dec_i),
    .rel_b    (rel_i),
    .hold_lvl (sus_i[LVL_W-1:0]),
    .phase_d  (phase_d),
    .level_d  (level_d),
    .side_en  (side_en),
    .side_step(side_step)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      level_q <= '0;
    end else if (tick_i) begin
      phase_q <= phase_d;
      level_q <= level_d;
    end
  end

  env_wave_track #(.WAVE_W(WAVE_W), .WAVE_TOP(WAVE_TOP)) u_wave (
    .clk   (clk),
    .rst   (rst),
    .upd   (tick_i && side_en),
    .step  (side_step),
    .wave_q(wave_o)
  );

  assign level_o = level_q;

  // R1: reset leaves silence and idle stage
  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (level_q == '0 && phase_q == PH_IDLE && wave_o == '0));
  // R2: no tick, no movement
  p_no_tick_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !tick_i |=> $stable(level_q) && $stable(phase_q));
  // R3: rise below the top adds the rate
  p_rise_add_r3: assert property (@(posedge clk) disable iff (rst)
    (tick_i && phase_q == PH_RISE && ({1'b0, level_q} + {1'b0, atk_i[6:3]}) < 5'd15)
    |=> level_q == $past(level_q) + $past(atk_i[6:3]));
  // R4: rise at or past the top clamps and turns to fall
  p_rise_clamp_r4: assert property (@(posedge clk) disable iff (rst)
    (tick_i && phase_q == PH_RISE && ({1'b0, level_q} + {1'b0, atk_i[6:3]}) >= 5'd15)
    |=> (level_q == 4'd15 && phase_q == PH_FALL));
  // R5, R6: fall and fade never go up and never go under the hold level
  p_fall_floor_r5: assert property (@(posedge clk) disable iff (rst)
    (tick_i && (phase_q == PH_FALL || phase_q == PH_FADE))
    |=> (level_q <= $past(level_q) && level_q >= $past(sus_i[3:0])));
  // R7: idle tick keeps the level
  p_idle_keep_r7: assert property (@(posedge clk) disable iff (rst)
    (tick_i && phase_q == PH_IDLE) |=> $stable(level_q));
endmodule

// File: tb/sim_env_adsr_ctrl.sv
`timescale 1ns/1ps
module sim_env_adsr_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic [7:0] atk = 8'h00, dec = 8'h80, sus = 8'hF0, rel = 8'h80;
  logic [3:0] level;
  logic [3:0] wave;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct {
    logic [3:0] lvl;
    logic [3:0] wav;
    string      tag;
  } exp_t;
  exp_t sb_q[$];

  always #4 clk = ~clk;

  env_adsr_ctrl u0 (
    .clk(clk), .rst(rst), .tick_i(tick),
    .atk_i(atk), .dec_i(dec), .sus_i(sus), .rel_i(rel),
    .level_o(level), .wave_o(wave)
  );

  function automatic logic [7:0] enc_rise(input int rate, input int side);
    return {1'b0, 4'(rate), 3'(side)};
  endfunction
  function automatic logic [7:0] enc_down(input int mag, input int side);
    return {1'b1, 4'(16 - mag), 3'(side)};
  endfunction
  function automatic logic [7:0] enc_hold(input int lv);
    return {4'hF, 4'(lv)};
  endfunction

  task automatic check(input string tag, input logic [3:0] al, input logic [3:0] aw,
                       input logic [3:0] el, input logic [3:0] ew);
    checks++;
    if (al !== el || aw !== ew) begin
      fails++;
      $display("FAIL %s: level=%0d wave=%0d expected level=%0d wave=%0d", tag, al, aw, el, ew);
    end
  endtask

  // driver: queue the expected result, then pulse tick
  task automatic step(input int el, input int ew, input string tag);
    exp_t e;
    e.lvl = 4'(el); e.wav = 4'(ew); e.tag = tag;
    sb_q.push_back(e);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    check("R1 reset", level, wave, 4'd0, 4'd0);
    @(negedge clk);
    check("R1 after reset", level, wave, 4'd0, 4'd0);
  endtask

  // monitor: compare after each ticked edge
  initial begin
    forever begin
      @(posedge clk);
      if (tick === 1'b1 && rst === 1'b0) begin
        @(negedge clk);
        if (sb_q.size() == 0) begin
          checks++; fails++;
          $display("FAIL scoreboard: result with no expected item, level=%0d wave=%0d expected none", level, wave);
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          check(e.tag, level, wave, e.lvl, e.wav);
        end
      end
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: level=%0d wave=%0d expected run to finish", level, wave);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();

    // basic envelope, no side values
    atk = enc_rise(4, 0); dec = enc_down(3, 0); rel = enc_down(2, 0); sus = enc_hold(0);
    step(0, 0, "R7 idle equal hold stays");
    sus = enc_hold(6);
    step(0, 0, "R7 raise hold selects rise, level kept");
    step(4, 0, "R3 rise +4");
    step(8, 0, "R3 rise +4");
    step(12, 0, "R3 rise +4");
    step(15, 0, "R4 overshoot clamps to 15");
    step(12, 0, "R5 fall -3");
    step(9, 0, "R5 fall -3");
    step(6, 0, "R5 reaches hold, idle");
    step(6, 0, "R7 idle holds");
    sus = enc_hold(1);
    step(6, 0, "R7 lower hold selects fade, level kept");
    step(4, 0, "R6 fade -2");
    step(2, 0, "R6 fade -2");
    step(1, 0, "R6 crosses below hold, settles at hold");
    sus = enc_hold(0);
    step(1, 0, "R7 lower hold to 0 selects fade");
    step(0, 0, "R6 would pass zero, settles at 0");

    // R2: writes without a tick move nothing
    sus = enc_hold(15); atk = enc_rise(15, 3);
    repeat (5) @(negedge clk);
    check("R2 no tick after write", level, wave, 4'd0, 4'd0);

    // exact top
    atk = enc_rise(15, 0);
    step(0, 0, "R7 raise to 15 selects rise");
    step(15, 0, "R4 exact 15 clamps");
    step(15, 0, "R5 hold 15 settles at once");
    step(15, 0, "R7 idle at 15");

    // side values of both signs
    do_reset();
    atk = enc_rise(5, 2); dec = enc_down(5, 6); rel = enc_down(5, 7); sus = enc_hold(8);
    step(0, 0, "R7 select rise, wave kept");
    step(5, 2, "R8 rise side +2");
    step(10, 4, "R8 rise side +2");
    step(15, 6, "R8 clamp with side +2");
    step(10, 4, "R8 fall side -2");
    step(8, 2, "R8 fall to hold, side -2");
    step(8, 2, "R8 idle leaves wave");
    sus = enc_hold(0);
    step(8, 2, "R8 select fade, wave kept");
    step(3, 1, "R8 fade side -1");
    step(0, 0, "R8 fade to 0, side -1");

    // clamp at top of offset range
    do_reset();
    atk = enc_rise(1, 3); dec = enc_down(15, 4); sus = enc_hold(15);
    step(0, 0, "R7 select rise");
    for (int i = 1; i <= 15; i++) begin
      int ew;
      ew = (3 * i > 13) ? 13 : 3 * i;
      step(i, ew, "R9 offset capped at 13");
    end
    sus = enc_hold(0);
    step(0, 9, "R5 fall by 15 to 0, side -4");

    // clamp at bottom
    do_reset();
    atk = enc_rise(15, 0); dec = enc_down(5, 4); sus = enc_hold(4);
    step(0, 0, "R7 select rise");
    step(15, 0, "R4 clamp, no side");
    step(10, 0, "R9 offset floored at 0");

    repeat (3) @(negedge clk);
    if (sb_q.size() != 0) begin
      checks++; fails++;
      $display("FAIL scoreboard: %0d items left, expected 0", sb_q.size());
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule